// File: doc/BRIEF.md
# Audio FIFO Service Request Throttle

This block sits beside an audio sample FIFO and decides when the FIFO needs attention. When the port transmits, it needs servicing whenever at least one entry is free. When the port receives, it needs servicing whenever at least one entry holds a sample. The block turns that condition into a DMA request, which it holds until the DMA engine acknowledges it. It can also drive the condition onto a service interrupt line, which has its own enable.

After each acknowledged request, a hold-off counter keeps the request low for a programmable number of bus clock cycles, from 0 to 31. This caps the share of bus bandwidth the audio port can take. The counter loads its value at the moment of the acknowledge, so software or the DMA engine can rewrite the setting at any time without disturbing a countdown that is already running.

FIFO overflow and underflow events set sticky flags. Each flag stays set until a write-one-to-clear pulse removes it. The flags drive an error interrupt through a separate enable.

Top module: `afst_top`

## Requirements
- R1: In transmit (`dir_rx`=0), the service condition is true when `fifo_level` < `DEPTH`. With no hold-off running and the request low, a true condition raises `dma_req` at the next clock edge.
- R2: In receive (`dir_rx`=1), the service condition is true when `fifo_level` > 0. A receive FIFO with `fifo_level`=0 never gets a new request.
- R3: Once `dma_req` is high, it stays high until `svc_ack` is sampled high, even if the service condition goes away.
- R4: If `svc_ack` is sampled high while `dma_req` is high, `dma_req` drops at that edge. It then stays low for exactly `holdoff_cfg`+1 cycles before it can rise again. With a setting of 0 there is one low cycle and the request comes back at the very next edge.
- R5: The hold-off length is the `holdoff_cfg` value present at the acknowledging edge. Changing `holdoff_cfg` during a countdown has no effect on that countdown. The new value applies from the next acknowledge.
- R6: An `svc_ack` sampled while `dma_req` is low is ignored and does not start a hold-off.
- R7: `svc_irq` is high exactly when `svc_irq_en` is 1 and the service condition is true. This is combinational, and the hold-off does not affect it.
- R8: `err_flags[0]` (overflow) and `err_flags[1]` (underflow) are set one edge after a high `fifo_ovf` or `fifo_unf` input. Each flag holds until a high bit in `err_clr` at the same position clears it. If a set and a clear arrive in the same cycle, the set wins.
- R9: `err_irq` is high exactly when `err_irq_en` is 1 and at least one of the `err_flags` bits is set.
- R10: A synchronous active-low `rst_n` clears the hold-off counter, `dma_req` and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_rx | input | 1 | 1 = receive, 0 = transmit |
| fifo_level | input | LVL_W | Number of filled FIFO entries, 0..DEPTH |
| fifo_ovf | input | 1 | FIFO overflow event pulse |
| fifo_unf | input | 1 | FIFO underflow event pulse |
| err_clr | input | 2 | Write-one-to-clear for the error flags (bit 0 overflow, bit 1 underflow) |
| svc_ack | input | 1 | DMA acknowledge of the pending request |
| holdoff_cfg | input | DLY_W | Hold-off cycles after each serviced request |
| svc_irq_en | input | 1 | Service interrupt enable |
| err_irq_en | input | 1 | Error interrupt enable |
| dma_req | output | 1 | DMA service request |
| svc_irq | output | 1 | Service interrupt |
| err_irq | output | 1 | Error interrupt |
| err_flags | output | 2 | Sticky error flags (bit 0 overflow, bit 1 underflow) |

## Verification
The bench builds the block with `DEPTH`=4 and `DLY_W`=5. With that setting, it can sweep every FIFO level from empty to full in both directions and measure the request gap for every one of the 32 hold-off values. The gap is counted cycle by cycle against `holdoff_cfg`+1. The small depth puts the empty and full boundaries only a few level steps apart. The bench also applies exact same-cycle collisions: a set against a clear on a flag, an acknowledge against a low request, and a configuration rewrite in the middle of a countdown.

// File: rtl/afst_pkg.sv
package afst_pkg;
   localparam int unsigned ERR_N   = 2;
   localparam int unsigned ERR_OVF = 0;
   localparam int unsigned ERR_UNF = 1;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } afst_dir_e;
endpackage

// File: rtl/afst_need.sv
module afst_need #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             dir_rx,
   input  logic [LVL_W-1:0] fifo_level,
   output logic             need
);
   import afst_pkg::*;

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   afst_dir_e dir;
   assign dir = afst_dir_e'(dir_rx);

   always_comb begin
      unique case (dir)
         DIR_TX:  need = (fifo_level < FULL_LVL);
         DIR_RX:  need = (fifo_level != '0);
         default: need = 1'b0;
      endcase
   end
endmodule

// File: rtl/afst_holdoff.sv
module afst_holdoff #(
   parameter int unsigned DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             need,
   input  logic             ack,
   input  logic [DLY_W-1:0] dly_cfg,
   output logic             req,
   output logic [DLY_W-1:0] cnt
);
   logic             req_q;
   logic [DLY_W-1:0] cnt_q;
   logic             serviced;

   assign serviced = req_q & ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         cnt_q <= '0;
      end else if (serviced) begin
         req_q <= 1'b0;
         cnt_q <= dly_cfg;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (!req_q && need) begin
         req_q <= 1'b1;
      end
   end

   assign req = req_q;
   assign cnt = cnt_q;
endmodule

// File: rtl/afst_sticky.sv
module afst_sticky #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      flag_q <= 1'b0;
         else if (set[i]) flag_q <= 1'b1;
         else if (clr[i]) flag_q <= 1'b0;
      end
      assign flags[i] = flag_q;
   end
endmodule

// File: rtl/afst_top.sv
module afst_top #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DLY_W = 5,
   parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dir_rx,
   input  logic [LVL_W-1:0]          fifo_level,
   input  logic                      fifo_ovf,
   input  logic                      fifo_unf,
   input  logic [afst_pkg::ERR_N-1:0] err_clr,
   input  logic                      svc_ack,
   input  logic [DLY_W-1:0]          holdoff_cfg,
   input  logic                      svc_irq_en,
   input  logic                      err_irq_en,
   output logic                      dma_req,
   output logic                      svc_irq,
   output logic                      err_irq,
   output logic [afst_pkg::ERR_N-1:0] err_flags
);
   import afst_pkg::*;

   initial begin
      if (DEPTH < 1)
         $error("afst_top: DEPTH must be at least 1");
      if (DLY_W < 1 || DLY_W > 16)
         $error("afst_top: DLY_W must be 1..16");
      if ((1 << LVL_W) <= DEPTH)
         $error("afst_top: LVL_W too narrow for DEPTH");
   end

   logic             need;
   logic [DLY_W-1:0] hold_cnt;
   logic [ERR_N-1:0] err_set;

   afst_need #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_need (
      .dir_rx     (dir_rx),
      .fifo_level (fifo_level),
      .need       (need)
   );

   afst_holdoff #(.DLY_W(DLY_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .need    (need),
      .ack     (svc_ack),
      .dly_cfg (holdoff_cfg),
      .req     (dma_req),
      .cnt     (hold_cnt)
   );

   always_comb begin
      err_set          = '0;
      err_set[ERR_OVF] = fifo_ovf;
      err_set[ERR_UNF] = fifo_unf;
   end

   afst_sticky #(.N(ERR_N)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .clr   (err_clr),
      .flags (err_flags)
   );

   assign svc_irq = svc_irq_en & need;
   assign err_irq = err_irq_en & (|err_flags);
endmodule

// File: rtl/afst_checker.sv
module afst_checker #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DLY_W = 5,
   parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dir_rx,
   input logic [LVL_W-1:0] fifo_level,
   input logic             fifo_ovf,
   input logic             fifo_unf,
   input logic [1:0]       err_clr,
   input logic             svc_ack,
   input logic             svc_irq_en,
   input logic             dma_req,
   input logic             svc_irq,
   input logic [1:0]       err_flags,
   input logic [DLY_W-1:0] hold_cnt
);
   p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !svc_ack |=> dma_req);

   p_drop_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && svc_ack |=> !dma_req);

   p_quiet_in_holdoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_req && hold_cnt != '0 |=> !dma_req);

   p_rx_empty_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dir_rx && fifo_level == '0 && !dma_req |=> !dma_req);

   p_ovf_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ovf |=> err_flags[0]);

   p_unf_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_flags[1] && !err_clr[1] |=> err_flags[1]);

   p_svc_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_irq_en |-> !svc_irq);

   p_reset_clears_r10: assert property (@(posedge clk)
      !rst_n |=> !dma_req && err_flags == 2'b00);
endmodule

bind afst_top afst_checker #(.DEPTH(DEPTH), .DLY_W(DLY_W), .LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dir_rx     (dir_rx),
   .fifo_level (fifo_level),
   .fifo_ovf   (fifo_ovf),
   .fifo_unf   (fifo_unf),
   .err_clr    (err_clr),
   .svc_ack    (svc_ack),
   .svc_irq_en (svc_irq_en),
   .dma_req    (dma_req),
   .svc_irq    (svc_irq),
   .err_flags  (err_flags),
   .hold_cnt   (hold_cnt)
);

// File: tb/afst_top_tb.sv
module afst_top_tb;
   localparam int unsigned DEPTH = 4;
   localparam int unsigned DLY_W = 5;
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n;
   logic             dir_rx;
   logic [LVL_W-1:0] fifo_level;
   logic             fifo_ovf, fifo_unf;
   logic [1:0]       err_clr;
   logic             svc_ack;
   logic [DLY_W-1:0] holdoff_cfg;
   logic             svc_irq_en, err_irq_en;
   logic             dma_req, svc_irq, err_irq;
   logic [1:0]       err_flags;

   int checks   = 0;
   int failures = 0;

   always #10 clk = ~clk;

   afst_top #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .fifo_level(fifo_level),
      .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf), .err_clr(err_clr),
      .svc_ack(svc_ack), .holdoff_cfg(holdoff_cfg), .svc_irq_en(svc_irq_en),
      .err_irq_en(err_irq_en), .dma_req(dma_req), .svc_irq(svc_irq),
      .err_irq(err_irq), .err_flags(err_flags)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   // Ack the pending request, then count low cycles until it returns.
   task automatic measure_gap(input int d_at_ack, input int d_after, output int gap);
      holdoff_cfg = DLY_W'(d_at_ack);
      svc_ack     = 1'b1;
      step(1);
      svc_ack     = 1'b0;
      holdoff_cfg = DLY_W'(d_after);
      gap = 0;
      while (!dma_req && gap < 100) begin
         gap++;
         step(1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int gap;
      dir_rx = 1'b0; fifo_level = '0; fifo_ovf = 1'b0; fifo_unf = 1'b0;
      err_clr = 2'b00; svc_ack = 1'b0; holdoff_cfg = '0;
      svc_irq_en = 1'b0; err_irq_en = 1'b1; rst_n = 1'b0;
      step(1);
      fifo_ovf = 1'b1; rst_n = 1'b1;
      step(1);
      fifo_ovf = 1'b0;
      check("R8 ovf set before reset", int'(err_flags), 1);
      fifo_level = LVL_W'(DEPTH);
      do_reset();
      // R10: reset clears flags and request
      check("R10 flags after reset", int'(err_flags), 0);
      check("R10 req after reset", int'(dma_req), 0);
      check("R10 err_irq after reset", int'(err_irq), 0);

      // R1 / R2 / R7: sweep direction x level x irq enable
      for (int dir = 0; dir < 2; dir++) begin
         for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            for (int en = 0; en < 2; en++) begin
               int need_exp;
               need_exp = (dir == 0) ? int'(lvl < DEPTH) : int'(lvl > 0);
               dir_rx = dir[0]; fifo_level = LVL_W'(lvl); svc_irq_en = en[0];
               do_reset();
               step(1);
               check(dir == 0 ? "R1 tx req" : "R2 rx req", int'(dma_req), need_exp);
               check("R7 svc_irq", int'(svc_irq), en * need_exp);
            end
         end
      end

      // R3: request held after the condition goes away
      dir_rx = 1'b0; fifo_level = '0; svc_irq_en = 1'b1;
      do_reset();
      step(1);
      check("R3 req raised", int'(dma_req), 1);
      fifo_level = LVL_W'(DEPTH);
      step(3);
      check("R3 req held without need", int'(dma_req), 1);
      check("R7 svc_irq follows need", int'(svc_irq), 0);
      holdoff_cfg = '0;
      svc_ack = 1'b1;
      step(1);
      svc_ack = 1'b0;
      check("R3 req drops on ack", int'(dma_req), 0);
      step(5);
      check("R3 no req without need", int'(dma_req), 0);

      // R6: ack while request low is ignored
      holdoff_cfg = DLY_W'(31);
      svc_ack = 1'b1; fifo_level = '0;
      step(1);
      svc_ack = 1'b0;
      check("R6 stray ack ignored", int'(dma_req), 1);

      // R4: every hold-off value
      for (int d = 0; d < (1 << DLY_W); d++) begin
         measure_gap(d, d, gap);
         check("R4 holdoff gap", gap, d + 1);
      end

      // R5: rewrite during countdown
      measure_gap(10, 0, gap);
      check("R5 countdown uses captured value", gap, 11);
      measure_gap(0, 20, gap);
      check("R5 new value from next ack", gap, 1);
      measure_gap(20, 3, gap);
      check("R5 long value captured", gap, 21);

      // R2: receive empty never requests after ack
      dir_rx = 1'b1; fifo_level = '0;
      measure_gap(0, 0, gap);
      check("R2 rx empty stays idle", gap, 100);

      // R8 / R9: sticky flags and error irq
      do_reset();
      err_irq_en = 1'b0;
      fifo_unf = 1'b1;
      step(1);
      fifo_unf = 1'b0;
      step(3);
      check("R8 unf sticky", int'(err_flags), 2);
      check("R9 err_irq disabled", int'(err_irq), 0);
      err_irq_en = 1'b1;
      step(1);
      check("R9 err_irq enabled", int'(err_irq), 1);
      fifo_ovf = 1'b1; err_clr = 2'b01;
      step(1);
      fifo_ovf = 1'b0; err_clr = 2'b00;
      check("R8 set beats clear", int'(err_flags), 3);
      err_clr = 2'b01;
      step(1);
      err_clr = 2'b00;
      check("R8 clear ovf only", int'(err_flags), 2);
      err_clr = 2'b10;
      step(1);
      err_clr = 2'b00;
      check("R8 clear unf", int'(err_flags), 0);
      check("R9 err_irq off when clear", int'(err_irq), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule